// File: doc/BRIEF.md
# Tagged-Word SPI Master

This block is a register-mapped SPI master that moves one character per transfer. Software sets the mode, character length and bit rate, writes a channel number and an end-of-frame mark into the transmit-control register, and then writes the character into the transmit-data register. That write starts the transfer. The block drives the serial clock and the outgoing data line, and samples the incoming line on the opposite clock edge. When the character has been shifted, the received bits land in the receive-data register. The channel and end-of-frame mark that travelled with the word are echoed into the receive-control register.

The chip select of the tagged channel goes low before the first clock edge. It stays low across words until a word marked end-of-frame completes, so one device can be addressed with a multi-word frame without software toggling the select. Readiness flags, two sticky error flags and a maskable interrupt let software pace the transfers by polling or by interrupt.

Top module: `spim_top`

## Requirements
- R1: After reset the bit-rate register (0x48) reads 1, the status register (0x44) reads 0, the interrupt status register (0x68) reads 0x0A, `irq` is 0, all four `csN` lines are high and `sclk` is low.
- R2: A write to transmit data (0x50) starts one word only when the configuration register (0x40) has bit 31 (enable) and bit 11 (master) set and no word is in flight. Status bit 1 reads 1 while the word is in flight. With the enable bit clear the write is ignored: no select falls and status stays 0.
- R3: Configuration bits [1:0] set the character length to 8, 16, 24 or 32 bits (codes 0 to 3). Data is shifted most significant bit first, and the received bits are right-aligned in receive data (0x58).
- R4: Configuration bit 14 is the idle level of `sclk`. With configuration bit 13 clear, `miso` is sampled on the leading edge of each clock pulse. With bit 13 set, it is sampled on the trailing edge. `mosi` changes on the other edge.
- R5: A bit-rate code n (bits [2:0] of 0x48) gives a half period of 2^(n-1) clock cycles, so `sclk` runs at the clock divided by 2^n. Code 0 behaves as code 1.
- R6: Transmit control (0x4C) bits [1:0] pick which `csN` line is driven low for the word. The line falls before the first `sclk` edge, and at most one line is low at any time.
- R7: Transmit control bit 2 marks a word as end-of-frame. After a word without the mark, the select stays low. After a word with the mark, all selects return high.
- R8: When a word completes, receive control (0x54) bits [1:0] and bit 2 hold the channel and end-of-frame mark of that word.
- R9: Interrupt status bits 3 and 1 read 1 when no word is in flight. Bits 2 and 0 read 1 when a received word is unread. A read of receive data clears bits 2 and 0.
- R10: A word that completes while the previous received word is still unread sets interrupt status bit 6. The bit stays set until software writes 1 to it.
- R11: A write to transmit data while a word is in flight is dropped and sets interrupt status bit 7. The bit stays set until software writes 1 to it.
- R12: `irq` is high when any bit of interrupt status is set together with the same bit of the interrupt enable register (0x6C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (side effects on receive data) |
| busAddr | input | 8 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Active-low chip selects, one per channel |

## Verification
The in-line assertions check, on every cycle, that at most one select is low, that a select is held for the whole time a word is in flight, and that the clock is back at its idle level when a word ends. They also check that the sample and shift events never coincide, and that the two sticky error flags rise on the cycle after their cause. Only the bench scenarios show the correct bit order and alignment for each length and mode, the half-period timing per rate code, the echo of tags, the hold of the select across a frame, and the dropped writes. The bench uses a serial slave model that captures `mosi` and plays back `miso` words.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFF_CFG     = 8'h40;
  localparam logic [7:0] OFF_STAT    = 8'h44;
  localparam logic [7:0] OFF_RATE    = 8'h48;
  localparam logic [7:0] OFF_TXCTL   = 8'h4C;
  localparam logic [7:0] OFF_TXDATA  = 8'h50;
  localparam logic [7:0] OFF_RXCTL   = 8'h54;
  localparam logic [7:0] OFF_RXDATA  = 8'h58;
  localparam logic [7:0] OFF_INTSTAT = 8'h68;
  localparam logic [7:0] OFF_INTEN   = 8'h6C;

  // strobes from control to datapath
  typedef struct packed {
    logic load;          // capture a new word
    logic presentFirst;  // put MSB on mosi at load time (leading-edge sampling)
    logic shiftOut;      // advance mosi to next bit
    logic sample;        // shift miso into receive register
    logic finish;        // word complete
  } spim_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } spim_state_t;
endpackage

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  spim_strobe_t      strb,
  input  logic [DATA_W-1:0] txWord,
  input  logic [1:0]        charLen,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxWord
);
  logic [DATA_W-1:0] txSh;
  logic [DATA_W-1:0] rxSh;
  logic              mosiQ;
  logic [DATA_W-1:0] aligned;
  logic [4:0]        shAmt;

  // left-align the character: shift by (3 - len) bytes
  assign shAmt   = {~charLen, 3'b000};
  assign aligned = txWord << shAmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh  <= '0;
      rxSh  <= '0;
      mosiQ <= 1'b0;
    end else if (strb.load) begin
      rxSh <= '0;
      if (strb.presentFirst) begin
        mosiQ <= aligned[DATA_W-1];
        txSh  <= aligned << 1;
      end else begin
        txSh  <= aligned;
      end
    end else begin
      if (strb.shiftOut) begin
        mosiQ <= txSh[DATA_W-1];
        txSh  <= txSh << 1;
      end
      if (strb.sample) begin
        rxSh <= {rxSh[DATA_W-2:0], miso};
      end
    end
  end

  assign mosi   = mosiQ;
  assign rxWord = rxSh;

  // R4: a bit is never shifted out and sampled on the same edge
  assert_edge_split_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.sample && strb.shiftOut));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int RATE_W = 3,
  localparam int CH_W  = $clog2(NUM_CS),
  localparam int DIV_W = (1 << RATE_W) - 1,
  localparam int EDGE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CH_W-1:0]   startCh,
  input  logic              startEof,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic [1:0]        cfgLen,
  input  logic [RATE_W-1:0] rateCode,
  output spim_strobe_t      strb,
  output logic              busy,
  output logic              sclk,
  output logic [NUM_CS-1:0] csN,
  output logic [CH_W-1:0]   curCh,
  output logic              curEof
);
  spim_state_t       state;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  halfQ;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] lastEdge;
  logic [1:0]        lenQ;
  logic [2:0]        lenP1;
  logic              cphaQ;
  logic              cpolQ;
  logic              sclkQ;
  logic              csActive;
  logic              tick;
  logic              leading;
  logic [DIV_W-1:0]  halfNew;

  // half period in clock cycles: 2^(n-1), code 0 clamped to 1
  always_comb begin
    if (rateCode == '0) halfNew = DIV_W'(1);
    else                halfNew = DIV_W'(1) << (rateCode - RATE_W'(1));
  end

  assign lenP1    = {1'b0, lenQ} + 3'd1;
  assign lastEdge = {lenP1, 4'b0000} - EDGE_W'(1);
  assign tick     = (state != ST_IDLE) && (divCnt == '0);
  assign leading  = ~edgeCnt[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      halfQ    <= DIV_W'(1);
      edgeCnt  <= '0;
      lenQ     <= '0;
      cphaQ    <= 1'b0;
      cpolQ    <= 1'b0;
      sclkQ    <= 1'b0;
      csActive <= 1'b0;
      curCh    <= '0;
      curEof   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          sclkQ <= cfgCpol;
          if (start) begin
            state    <= ST_RUN;
            csActive <= 1'b1;
            curCh    <= startCh;
            curEof   <= startEof;
            cphaQ    <= cfgCpha;
            cpolQ    <= cfgCpol;
            lenQ     <= cfgLen;
            halfQ    <= halfNew;
            divCnt   <= halfNew - DIV_W'(1);
            edgeCnt  <= '0;
          end
        end
        ST_RUN: begin
          if (tick) begin
            divCnt  <= halfQ - DIV_W'(1);
            sclkQ   <= ~sclkQ;
            edgeCnt <= edgeCnt + EDGE_W'(1);
            if (edgeCnt == lastEdge) state <= ST_HOLD;
          end else begin
            divCnt <= divCnt - DIV_W'(1);
          end
        end
        ST_HOLD: begin
          if (tick) begin
            state <= ST_IDLE;
            if (curEof) csActive <= 1'b0;
          end else begin
            divCnt <= divCnt - DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb              = '0;
    strb.load         = (state == ST_IDLE) && start;
    strb.presentFirst = ~cfgCpha;
    if (state == ST_RUN && tick) begin
      strb.shiftOut = cphaQ ? leading : (!leading && edgeCnt != lastEdge);
      strb.sample   = cphaQ ? !leading : leading;
    end
    strb.finish = (state == ST_HOLD) && tick;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CS; gi++) begin : g_cs
      assign csN[gi] = ~(csActive && (curCh == CH_W'(gi)));
    end
  endgenerate

  assign busy = (state != ST_IDLE);
  assign sclk = sclkQ;

  // R6: never more than one select low
  assert_one_select_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  // R7: a select stays low while a word is in flight
  assert_select_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (csN != {NUM_CS{1'b1}}));
  // R4: the clock is back at its idle level when the word ends
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |-> (sclk == cpolQ));
  // R2: strobes only while a word is in flight
  assert_no_stray_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(strb.sample || strb.shiftOut || strb.finish));
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int RATE_W = 3,
  localparam int CH_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  input  logic              busy,
  input  logic              finish,
  input  logic [DATA_W-1:0] rxWord,
  input  logic [CH_W-1:0]   doneCh,
  input  logic              doneEof,
  output logic              start,
  output logic [DATA_W-1:0] startData,
  output logic [CH_W-1:0]   txCh,
  output logic              txEof,
  output logic              cfgCpol,
  output logic              cfgCpha,
  output logic [1:0]        cfgLen,
  output logic [RATE_W-1:0] rateCode
);
  logic              cfgEn;
  logic              cfgMaster;
  logic [CH_W-1:0]   rxCh;
  logic              rxEof;
  logic [DATA_W-1:0] rxData;
  logic              rxReady;
  logic              errTxColl;
  logic              errRxOvr;
  logic [7:0]        intEn;
  logic [7:0]        intStat;
  logic              wrTx;
  logic              rdRx;
  logic              wrW1c;

  assign wrTx      = busWr && (busAddr == OFF_TXDATA);
  assign rdRx      = busRd && (busAddr == OFF_RXDATA);
  assign wrW1c     = busWr && (busAddr == OFF_INTSTAT);
  assign start     = wrTx && cfgEn && cfgMaster && !busy;
  assign startData = busWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn     <= 1'b0;
      cfgMaster <= 1'b0;
      cfgCpol   <= 1'b0;
      cfgCpha   <= 1'b0;
      cfgLen    <= 2'd0;
      rateCode  <= RATE_W'(1);
      txCh      <= '0;
      txEof     <= 1'b0;
      intEn     <= '0;
    end else if (busWr) begin
      case (busAddr)
        OFF_CFG: begin
          cfgEn     <= busWdata[31];
          cfgCpol   <= busWdata[14];
          cfgCpha   <= busWdata[13];
          cfgMaster <= busWdata[11];
          cfgLen    <= busWdata[1:0];
        end
        OFF_RATE:  rateCode <= busWdata[RATE_W-1:0];
        OFF_TXCTL: begin
          txCh  <= busWdata[CH_W-1:0];
          txEof <= busWdata[2];
        end
        OFF_INTEN: intEn <= busWdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCh      <= '0;
      rxEof     <= 1'b0;
      rxData    <= '0;
      rxReady   <= 1'b0;
      errTxColl <= 1'b0;
      errRxOvr  <= 1'b0;
    end else begin
      if (finish) begin
        rxData  <= rxWord;
        rxCh    <= doneCh;
        rxEof   <= doneEof;
        rxReady <= 1'b1;
      end else if (rdRx) begin
        rxReady <= 1'b0;
      end

      if (finish && rxReady && !rdRx) errRxOvr <= 1'b1;
      else if (wrW1c && busWdata[6])  errRxOvr <= 1'b0;

      if (wrTx && busy)               errTxColl <= 1'b1;
      else if (wrW1c && busWdata[7])  errTxColl <= 1'b0;
    end
  end

  assign intStat = {errTxColl, errRxOvr, 2'b00, !busy, rxReady, !busy, rxReady};
  assign irq     = |(intStat & intEn);

  always_comb begin
    case (busAddr)
      OFF_CFG:     busRdata = {cfgEn, 16'b0, cfgCpol, cfgCpha, 1'b0, cfgMaster, 9'b0, cfgLen};
      OFF_STAT:    busRdata = {30'b0, busy, 1'b0};
      OFF_RATE:    busRdata = DATA_W'(rateCode);
      OFF_TXCTL:   busRdata = DATA_W'({txEof, txCh});
      OFF_RXCTL:   busRdata = DATA_W'({rxEof, rxCh});
      OFF_RXDATA:  busRdata = rxData;
      OFF_INTSTAT: busRdata = DATA_W'(intStat);
      OFF_INTEN:   busRdata = DATA_W'(intEn);
      default:     busRdata = '0;
    endcase
  end

  // R10: an unread word overwritten raises the overrun flag
  assert_rx_overrun_R10: assert property (@(posedge clk) disable iff (!rstN)
    (finish && rxReady && !rdRx) |=> errRxOvr);
  // R11: a transmit write during a word raises the collision flag
  assert_tx_collision_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrTx && busy) |=> errTxColl);
  // R9: a completed word always leaves the ready flag set
  assert_rx_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> rxReady);
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int RATE_W = 3,
  localparam int CH_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN
);
  spim_strobe_t      strb;
  logic              busy;
  logic              start;
  logic [DATA_W-1:0] startData;
  logic [CH_W-1:0]   txCh;
  logic              txEof;
  logic              cfgCpol;
  logic              cfgCpha;
  logic [1:0]        cfgLen;
  logic [RATE_W-1:0] rateCode;
  logic [DATA_W-1:0] rxWord;
  logic [CH_W-1:0]   curCh;
  logic              curEof;

  spim_regs #(.NUM_CS(NUM_CS), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rstN(rstN),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq),
    .busy(busy), .finish(strb.finish), .rxWord(rxWord),
    .doneCh(curCh), .doneEof(curEof),
    .start(start), .startData(startData), .txCh(txCh), .txEof(txEof),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgLen(cfgLen), .rateCode(rateCode)
  );

  spim_ctrl #(.NUM_CS(NUM_CS), .RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .start(start), .startCh(txCh), .startEof(txEof),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgLen(cfgLen), .rateCode(rateCode),
    .strb(strb), .busy(busy), .sclk(sclk), .csN(csN),
    .curCh(curCh), .curEof(curEof)
  );

  spim_dp u_dp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .txWord(startData), .charLen(cfgLen),
    .miso(miso), .mosi(mosi), .rxWord(rxWord)
  );
endmodule

// File: tb/spim_top_tb.sv
`timescale 1ns/1ps
module spim_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  logic        sclk;
  logic        mosi;
  logic        miso;
  logic [3:0]  csN;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spim_top u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .csN(csN)
  );

  // ---------------- serial slave model ----------------
  logic        sCpol = 0, sCpha = 0;
  logic [31:0] sTx = '0, sRx = '0;
  int          sPos = 0;
  logic        misoR = 1'b0;
  int          wEdges = 0;
  realtime     lastEdgeT = 0;
  int          halfMeas = 0;
  assign miso = misoR;

  always @(sclk) begin
    if (csN != 4'hF) begin
      if (wEdges > 0) halfMeas = int'(($realtime - lastEdgeT) / 5.0);
      lastEdgeT = $realtime;
      wEdges++;
      if (sclk == (sCpol == sCpha)) begin
        sRx = {sRx[30:0], mosi};
        sPos++;
        if (sPos < 32) misoR = sTx[31 - sPos];
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [31:0] lenMask(input logic [1:0] len);
    return (len == 2'd3) ? 32'hFFFF_FFFF : ((32'd1 << (8 * (len + 1))) - 1);
  endfunction

  function automatic int expHalf(input logic [2:0] rate);
    return (rate == 0) ? 1 : (1 << (rate - 1));
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%08h exp=0x%08h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic waitIdle(output logic firstBusy);
    logic [31:0] s;
    rd(8'h44, s);
    firstBusy = s[1];
    while (s[1]) rd(8'h44, s);
  endtask

  // one word: configure, arm slave, launch, wait, optionally read back and check
  task automatic doWord(input logic [1:0] ch, input logic eof, input logic [1:0] len,
                        input logic cp, input logic ph, input logic [2:0] rate,
                        input logic [31:0] mdat, input logic [31:0] sdat,
                        input bit readBack, input string tag);
    logic [31:0] r;
    logic fb;
    int bits;
    bits = 8 * (len + 1);
    wr(8'h40, (32'h1 << 31) | (32'h1 << 11) | (32'(cp) << 14) | (32'(ph) << 13) | 32'(len));
    wr(8'h48, 32'(rate));
    wr(8'h4C, {29'b0, eof, ch});
    sCpol = cp; sCpha = ph;
    sTx = sdat << (32 - bits);
    sRx = '0; sPos = 0; misoR = sTx[31]; wEdges = 0;
    wr(8'h50, mdat);
    waitIdle(fb);
    chk(fb == 1'b1, {"R2 busy during word ", tag}, 32'(fb), 32'h1);
    chk((sRx & lenMask(len)) == (mdat & lenMask(len)), {"R3/R4 slave saw mosi ", tag},
        sRx & lenMask(len), mdat & lenMask(len));
    if (readBack) begin
      rd(8'h54, r);
      chk(r == {29'b0, eof, ch}, {"R8 rx tag ", tag}, r, {29'b0, eof, ch});
      rd(8'h58, r);
      chk(r == (sdat & lenMask(len)), {"R3/R4 rx data ", tag}, r, sdat & lenMask(len));
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired act=0x0 exp=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] r;
    logic fb;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(csN == 4'hF && sclk == 1'b0, "R1 csN/sclk at reset", {27'b0, sclk, csN}, 32'hF);
    chk(irq == 1'b0, "R1 irq at reset", 32'(irq), 32'h0);
    rd(8'h48, r); chk(r == 32'h1, "R1 rate reset", r, 32'h1);
    rd(8'h44, r); chk(r == 32'h0, "R1 status reset", r, 32'h0);
    rd(8'h68, r); chk(r == 32'h0A, "R1 intstat reset R9", r, 32'h0A);

    // R2 disabled: write is ignored
    wr(8'h40, 32'h0);
    wr(8'h50, 32'hA5);
    repeat (4) @(negedge clk);
    chk(csN == 4'hF, "R2 disabled no select", 32'(csN), 32'hF);
    rd(8'h44, r); chk(r == 32'h0, "R2 disabled not busy", r, 32'h0);

    // R3/R4/R6 directed 8-bit word, mode 0
    doWord(2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 3'd1, 32'hA5, 32'h3C, 1, "mode0 8b");
    chk(csN == 4'hF, "R7 eof releases select", 32'(csN), 32'hF);

    // R5 timing: code 3 -> half period 4, code 0 -> half period 1
    doWord(2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 3'd3, 32'h81, 32'h7E, 1, "rate3");
    chk(halfMeas == expHalf(3'd3), "R5 half period code 3", 32'(halfMeas), 32'(expHalf(3'd3)));
    doWord(2'd1, 1'b1, 2'd0, 1'b1, 1'b1, 3'd0, 32'h5A, 32'hC3, 1, "rate0");
    chk(halfMeas == expHalf(3'd0), "R5 half period code 0", 32'(halfMeas), 32'(expHalf(3'd0)));

    // R4 idle level follows polarity
    wr(8'h40, (32'h1 << 31) | (32'h1 << 11) | (32'h1 << 14));
    repeat (2) @(negedge clk);
    chk(sclk == 1'b1, "R4 idle level high", 32'(sclk), 32'h1);

    // R6/R7 non-eof word holds channel 2 select, then eof releases
    doWord(2'd2, 1'b0, 2'd1, 1'b1, 1'b0, 3'd2, 32'h1234, 32'hBEEF, 1, "frame w1");
    repeat (3) @(negedge clk);
    chk(csN == 4'b1011, "R6/R7 select held after non-eof word", 32'(csN), 32'hB);
    doWord(2'd2, 1'b1, 2'd1, 1'b1, 1'b0, 3'd2, 32'h5678, 32'hCAFE, 1, "frame w2");
    chk(csN == 4'hF, "R7 select released after eof", 32'(csN), 32'hF);

    // R12 + R9: rx-ready interrupt, read clears
    wr(8'h6C, 32'h04);
    doWord(2'd3, 1'b1, 2'd2, 1'b0, 1'b1, 3'd1, 32'h00ABCDEF, 32'h00123456, 0, "irq");
    @(negedge clk);
    chk(irq == 1'b1, "R12 irq on rx ready", 32'(irq), 32'h1);
    rd(8'h68, r); chk(r == 32'h0F, "R9 intstat unread", r, 32'h0F);
    rd(8'h58, r); chk(r == 32'h00123456, "R3 24-bit rx", r, 32'h00123456);
    @(negedge clk);
    chk(irq == 1'b0, "R12/R9 irq cleared by read", 32'(irq), 32'h0);
    wr(8'h6C, 32'h0);

    // R10 overrun: two words, no read
    doWord(2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 3'd1, 32'h11, 32'h22, 0, "ovr1");
    doWord(2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 3'd1, 32'h33, 32'h44, 0, "ovr2");
    rd(8'h68, r); chk(r[6] == 1'b1, "R10 overrun set", r, r | 32'h40);
    rd(8'h58, r); chk(r == 32'h44, "R10 latest word kept", r, 32'h44);
    wr(8'h68, 32'h40);
    rd(8'h68, r); chk(r[6] == 1'b0, "R10 overrun cleared by W1C", r, r & ~32'h40);

    // R11 collision: second write while busy dropped
    wr(8'h40, (32'h1 << 31) | (32'h1 << 11) | 32'd3);
    wr(8'h48, 32'd4);
    wr(8'h4C, 32'h5);
    sCpol = 0; sCpha = 0; sTx = 32'h0F0F_F0F0; sRx = '0; sPos = 0; misoR = sTx[31]; wEdges = 0;
    wr(8'h50, 32'hDEAD_BEEF);
    wr(8'h50, 32'h1111_1111);
    waitIdle(fb);
    chk(sRx == 32'hDEAD_BEEF, "R11 second write dropped", sRx, 32'hDEAD_BEEF);
    rd(8'h68, r); chk(r[7] == 1'b1, "R11 collision flag", r, r | 32'h80);
    rd(8'h58, r); chk(r == 32'h0F0F_F0F0, "R3 32-bit rx", r, 32'h0F0F_F0F0);
    rd(8'h54, r); chk(r == 32'h5, "R8 tag ch1 eof", r, 32'h5);
    wr(8'h68, 32'h80);
    rd(8'h68, r); chk(r == 32'h0A, "R11 collision cleared", r, 32'h0A);
    chk(csN == 4'hF, "R7 released after eof", 32'(csN), 32'hF);

    // random words, each ending a frame so mode may change between them
    for (int i = 0; i < 24; i++) begin
      logic [1:0] ch, len;
      logic cp, ph;
      logic [2:0] rt;
      logic [31:0] md, sd;
      ch = 2'($urandom_range(0, 3));
      len = 2'($urandom_range(0, 3));
      cp = 1'($urandom_range(0, 1));
      ph = 1'($urandom_range(0, 1));
      rt = 3'($urandom_range(0, 3));
      md = $urandom();
      sd = $urandom();
      doWord(ch, 1'b1, len, cp, ph, rt, md, sd, 1, $sformatf("rand%0d", i));
      chk(halfMeas == expHalf(rt), "R5 random half period", 32'(halfMeas), 32'(expHalf(rt)));
      chk(csN == 4'hF, "R6 random select released", 32'(csN), 32'hF);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule